// File: doc/BRIEF.md
# Reassembly Timeout Round-Robin Scanner

This block finds logical channels (LCs) whose packet reassembly has stalled. Each LC in a small internal table holds an enable bit, a connection-type code, a one-bit "touched" marker and an error flag. A prescaled time base counts up to a programmed limit. Each time it reaches the limit, the block examines one LC. A pointer walks round-robin between a lower and an upper table bound. Ineligible entries are passed over one per cycle until an eligible LC has been examined or the whole range has been walked.

On an eligible LC, a clear marker is set. A marker that is already set means no cell and no packet completion arrived on that LC for a whole scan round. That LC is then put into the error state, its marker is cleared and a one-cycle timeout event carrying its index is raised. The event tells downstream logic to free the packet or report it. Cell arrivals and packet completions clear the marker through a dedicated port. The cell pipeline's busy signal always takes precedence over scanning, so under load the timing stretches without limit.

Top module: `rto_scanner`

## Requirements
- R1: With prescaler value P and a nonzero limit L, the time base advances once every P+1 cycles. It raises a check request when it equals L, holds while the request is pending, and restarts from zero only after the check has finished.
- R2: Only LCs that are enabled, carry a 3-bit type code of 5, 6 or 7 and are not in error are examined; all others are passed over with their marker unchanged.
- R3: The scan pointer stays within the lower and upper bounds inclusive and wraps from the upper bound back to the lower one; a pointer outside the range moves to the lower bound.
- R4: Examining an eligible LC whose marker is clear sets the marker and raises no event.
- R5: Examining an eligible LC whose marker is set raises to_valid for one cycle with to_idx equal to that LC, sets its error flag and clears its marker.
- R6: A clear request clears the marker of the named LC; a clear on the same cycle as an examination of that LC wins, so no marker is set and no timeout is raised.
- R7: While cell_busy is high no LC is examined and the pending request waits.
- R8: A marker that is set when its LC is disabled stays set while the LC remains disabled.
- R9: A limit of zero keeps the scanner idle: no LC is examined and no event is raised.
- R10: A configuration write to an LC loads its enable bit and type code and clears its error flag.
- R11: An LC in error is not examined again and raises no further events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_presc | input | PRESC_W | Prescaler terminal value P |
| cfg_limit | input | LIMIT_W | Time-base compare value L, zero idles the scanner |
| cfg_lo | input | IDX_W | Lower table bound |
| cfg_hi | input | IDX_W | Upper table bound |
| lc_wr | input | 1 | LC configuration write strobe |
| lc_wr_idx | input | IDX_W | LC written |
| lc_wr_en | input | 1 | Timeout-enable bit written |
| lc_wr_type | input | 3 | Connection-type code written |
| clr_valid | input | 1 | Cell arrival or packet completion on an LC |
| clr_idx | input | IDX_W | LC to clear |
| cell_busy | input | 1 | Cell pipeline has work pending |
| q_idx | input | IDX_W | LC whose state is shown on q_touched and q_err |
| q_touched | output | 1 | Marker of LC q_idx |
| q_err | output | 1 | Error flag of LC q_idx |
| to_valid | output | 1 | Timeout event strobe |
| to_idx | output | IDX_W | LC that timed out |

## Verification
The scan runs over a range that mixes eligible LCs with a disabled entry, a wrong-type entry and an eligible LC outside the bounds. The order of the timeout events then shows whether the wrap and the skip rules are right. A stretch with cell_busy held, and a zero limit, show whether the scan waits or stays idle. A clear held on one LC for hundreds of cycles, while its neighbours time out, separates same-cycle clear precedence from a false timeout. Disabling an LC just after its marker was set shows whether a stale marker is kept.

// File: rtl/rto_pkg.sv
package rto_pkg;
    localparam int TYPE_W = 3;

    // connection types that take part in timeout scanning
    function automatic logic type_ok(input logic [TYPE_W-1:0] t);
        return (t == 3'd5) || (t == 3'd6) || (t == 3'd7);
    endfunction
endpackage

// File: rtl/rto_timebase.sv
module rto_timebase #(
    parameter int PRESC_W = 8,
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] cfg_presc,
    input  logic [LIMIT_W-1:0] cfg_limit,
    input  logic               check_done,
    output logic               pending
);
    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [LIMIT_W-1:0] tb;
    } tb_state_t;

    tb_state_t s_q, s_d;
    logic      armed;

    always_comb begin
        armed   = (cfg_limit != '0);
        pending = armed && (s_q.tb == cfg_limit);
        s_d     = s_q;
        if (!armed || s_q.tb > cfg_limit) begin
            s_d = '0;
        end else if (pending) begin
            if (check_done) s_d = '0;
        end else if (s_q.presc == cfg_presc) begin
            s_d.presc = '0;
            s_d.tb    = s_q.tb + 1'b1;
        end else begin
            s_d.presc = s_q.presc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1: time base frozen while the request waits, unless the limit moved
    assert_tb_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !check_done |=> (s_q.tb == $past(s_q.tb)) || (cfg_limit != $past(cfg_limit)));
endmodule

// File: rtl/rto_lc_table.sv
module rto_lc_table #(
    parameter int NUM_LC = 16,
    localparam int IDX_W = $clog2(NUM_LC)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic                       wr_lc_en,
    input  logic [rto_pkg::TYPE_W-1:0] wr_type,
    input  logic                       clr_valid,
    input  logic [IDX_W-1:0]           clr_idx,
    input  logic [IDX_W-1:0]           vis_idx,
    input  logic                       vis_set,
    input  logic                       vis_fault,
    output logic                       vis_elig,
    output logic                       vis_touched,
    input  logic [IDX_W-1:0]           q_idx,
    output logic                       q_touched,
    output logic                       q_err
);
    typedef struct packed {
        logic [NUM_LC-1:0]                          en;
        logic [NUM_LC-1:0]                          touched;
        logic [NUM_LC-1:0]                          err;
        logic [NUM_LC-1:0][rto_pkg::TYPE_W-1:0]     typ;
    } tbl_t;

    tbl_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (vis_set) t_d.touched[vis_idx] = 1'b1;
        if (vis_fault) begin
            t_d.err[vis_idx]     = 1'b1;
            t_d.touched[vis_idx] = 1'b0;
        end
        if (clr_valid) t_d.touched[clr_idx] = 1'b0;
        if (wr_en) begin
            t_d.en[wr_idx]  = wr_lc_en;
            t_d.typ[wr_idx] = wr_type;
            t_d.err[wr_idx] = 1'b0;
        end
        vis_elig    = t_q.en[vis_idx] && rto_pkg::type_ok(t_q.typ[vis_idx]) && !t_q.err[vis_idx];
        vis_touched = t_q.touched[vis_idx];
        q_touched   = t_q.touched[q_idx];
        q_err       = t_q.err[q_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R5: a fault leaves the LC in error with its marker cleared
    assert_fault_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vis_fault && !(wr_en && wr_idx == vis_idx)
        |=> t_q.err[$past(vis_idx)] && !t_q.touched[$past(vis_idx)]);
    // R6: a clear request always leaves the marker low
    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |=> !t_q.touched[$past(clr_idx)]);
endmodule

// File: rtl/rto_scan.sv
module rto_scan #(
    parameter int NUM_LC = 16,
    localparam int IDX_W = $clog2(NUM_LC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pending,
    input  logic             cell_busy,
    input  logic [IDX_W-1:0] cfg_lo,
    input  logic [IDX_W-1:0] cfg_hi,
    input  logic             clr_valid,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             vis_elig,
    input  logic             vis_touched,
    output logic [IDX_W-1:0] vis_idx,
    output logic             vis_set,
    output logic             vis_fault,
    output logic             check_done,
    output logic             to_valid,
    output logic [IDX_W-1:0] to_idx
);
    typedef struct packed {
        logic [IDX_W-1:0] ptr;
        logic [IDX_W:0]   walk;
        logic             ev;
        logic [IDX_W-1:0] ev_idx;
    } scan_t;

    scan_t s_q, s_d;
    logic  act, in_range, span_ok, here, hit_clr, last;
    logic [IDX_W-1:0] nxt;

    always_comb begin
        act      = pending && !cell_busy;
        span_ok  = cfg_hi >= cfg_lo;
        in_range = (s_q.ptr >= cfg_lo) && (s_q.ptr <= cfg_hi);
        nxt      = (!in_range || s_q.ptr == cfg_hi) ? cfg_lo : s_q.ptr + 1'b1;
        here     = in_range && vis_elig;
        hit_clr  = clr_valid && (clr_idx == s_q.ptr);
        last     = !span_ok || (s_q.walk >= {1'b0, cfg_hi - cfg_lo});
        check_done = act && (here || last);
        vis_idx    = s_q.ptr;
        vis_set    = act && here && !vis_touched && !hit_clr;
        vis_fault  = act && here && vis_touched && !hit_clr;

        s_d        = s_q;
        s_d.ev     = vis_fault;
        if (vis_fault) s_d.ev_idx = s_q.ptr;
        if (act) begin
            if (span_ok) s_d.ptr = nxt;
            s_d.walk = check_done ? '0 : s_q.walk + 1'b1;
        end
        to_valid = s_q.ev;
        to_idx   = s_q.ev_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: nothing examined while the cell pipeline is busy
    assert_busy_yields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cell_busy |-> !check_done && !vis_set && !vis_fault);
    // R5: an event only follows a visit to a marked LC
    assert_event_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        to_valid |-> $past(vis_touched) && $past(pending));
    // R3: after a step the pointer lies within the bounds
    assert_in_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act && span_ok |=> (s_q.ptr >= cfg_lo && s_q.ptr <= cfg_hi)
                           || cfg_lo != $past(cfg_lo) || cfg_hi != $past(cfg_hi));
endmodule

// File: rtl/rto_scanner.sv
module rto_scanner #(
    parameter int NUM_LC  = 16,
    parameter int PRESC_W = 8,
    parameter int LIMIT_W = 16,
    localparam int IDX_W  = $clog2(NUM_LC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] cfg_presc,
    input  logic [LIMIT_W-1:0] cfg_limit,
    input  logic [IDX_W-1:0]   cfg_lo,
    input  logic [IDX_W-1:0]   cfg_hi,
    input  logic               lc_wr,
    input  logic [IDX_W-1:0]   lc_wr_idx,
    input  logic               lc_wr_en,
    input  logic [2:0]         lc_wr_type,
    input  logic               clr_valid,
    input  logic [IDX_W-1:0]   clr_idx,
    input  logic               cell_busy,
    input  logic [IDX_W-1:0]   q_idx,
    output logic               q_touched,
    output logic               q_err,
    output logic               to_valid,
    output logic [IDX_W-1:0]   to_idx
);
    logic             pending, check_done, vis_set, vis_fault, vis_elig, vis_touched;
    logic [IDX_W-1:0] vis_idx;

    rto_timebase #(.PRESC_W(PRESC_W), .LIMIT_W(LIMIT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .cfg_presc(cfg_presc), .cfg_limit(cfg_limit),
        .check_done(check_done), .pending(pending));

    rto_scan #(.NUM_LC(NUM_LC)) u_scan (
        .clk(clk), .rst_n(rst_n), .pending(pending), .cell_busy(cell_busy),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .clr_valid(clr_valid), .clr_idx(clr_idx),
        .vis_elig(vis_elig), .vis_touched(vis_touched), .vis_idx(vis_idx),
        .vis_set(vis_set), .vis_fault(vis_fault), .check_done(check_done),
        .to_valid(to_valid), .to_idx(to_idx));

    rto_lc_table #(.NUM_LC(NUM_LC)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(lc_wr), .wr_idx(lc_wr_idx),
        .wr_lc_en(lc_wr_en), .wr_type(lc_wr_type), .clr_valid(clr_valid),
        .clr_idx(clr_idx), .vis_idx(vis_idx), .vis_set(vis_set),
        .vis_fault(vis_fault), .vis_elig(vis_elig), .vis_touched(vis_touched),
        .q_idx(q_idx), .q_touched(q_touched), .q_err(q_err));

    // R9: a zero limit never lets a check finish
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_limit == '0 |-> !check_done && !vis_set && !vis_fault);
    // R1: checks only complete against a pending request
    assert_done_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        check_done |-> pending);
endmodule

// File: tb/rto_scanner_tb.sv
`timescale 1ns/1ps
module rto_scanner_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_presc = '0;
    logic [15:0] cfg_limit = '0;
    logic [3:0] cfg_lo = '0, cfg_hi = '0;
    logic       lc_wr = 1'b0, lc_wr_en = 1'b0;
    logic [3:0] lc_wr_idx = '0;
    logic [2:0] lc_wr_type = '0;
    logic       clr_valid = 1'b0;
    logic [3:0] clr_idx = '0;
    logic       cell_busy = 1'b0;
    logic [3:0] q_idx = '0;
    logic       q_touched, q_err, to_valid;
    logic [3:0] to_idx;

    int total = 0, bad = 0, events = 0;
    logic [3:0] exp_q[$];

    always #2.5 clk = ~clk;

    rto_scanner u_dut (.*);

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic lc_set(input int idx, input logic en, input int typ);
        @(negedge clk);
        lc_wr = 1'b1; lc_wr_idx = 4'(idx); lc_wr_en = en; lc_wr_type = 3'(typ);
        @(negedge clk);
        lc_wr = 1'b0;
    endtask

    task automatic peek(input int idx, output logic t, output logic e);
        q_idx = 4'(idx);
        #0.1;
        t = q_touched; e = q_err;
    endtask

    task automatic wait_events(input string req, input int n, input int limit);
        for (int i = 0; i < limit && events < n; i++) @(negedge clk);
        check(req, events, n);
    endtask

    // monitor: compare each event against the scoreboard
    always @(negedge clk) begin
        if (rst_n && to_valid) begin
            events++;
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R5/R6/R11 unexpected event actual=%0d expected=none", to_idx);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                if (to_idx != e) begin
                    bad++;
                    $display("FAIL R3/R5 event order actual=%0d expected=%0d", to_idx, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic t, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("reset to_valid", to_valid, 0);
        peek(2, t, e); check("reset marker", t, 0); check("reset err", e, 0);

        cfg_lo = 4'd2; cfg_hi = 4'd6;
        lc_set(2, 1, 5); lc_set(3, 1, 6); lc_set(5, 1, 7);
        lc_set(4, 1, 1); lc_set(6, 0, 5); lc_set(7, 1, 5); lc_set(1, 1, 5);
        repeat (50) @(negedge clk);
        peek(2, t, e); check("R9 zero limit idle", t, 0);

        cell_busy = 1'b1; cfg_limit = 16'd2;
        repeat (100) @(negedge clk);
        peek(2, t, e); check("R7 busy postpones", t, 0);
        exp_q.push_back(4'd2); exp_q.push_back(4'd3); exp_q.push_back(4'd5);
        cell_busy = 1'b0;
        repeat (3) @(negedge clk);
        peek(2, t, e); check("R4 first visit marks", t, 1);
        peek(3, t, e); check("R1 one LC per match", t, 0);
        check("R4 no event on first visit", events, 0);
        wait_events("R5 timeouts", 3, 200);
        peek(2, t, e); check("R5 err LC2", e, 1); check("R5 marker LC2 cleared", t, 0);
        peek(5, t, e); check("R5 err LC5", e, 1);
        peek(4, t, e); check("R2 wrong type skipped", t, 0);
        peek(6, t, e); check("R2 disabled skipped", t, 0);
        peek(7, t, e); check("R3 above bound untouched", t, 0);
        peek(1, t, e); check("R3 below bound untouched", t, 0);
        repeat (100) @(negedge clk);
        check("R11 no repeat events", events, 3);

        cfg_presc = 8'd1; cfg_limit = 16'd3;
        clr_valid = 1'b1; clr_idx = 4'd2;
        exp_q.push_back(4'd3); exp_q.push_back(4'd5);
        lc_set(2, 1, 5); lc_set(3, 1, 6);
        peek(3, t, e); check("R10 write clears err", e, 0);
        lc_set(5, 1, 7);
        wait_events("R6 neighbours time out", 5, 600);
        repeat (300) @(negedge clk);
        check("R6 cleared LC no event", events, 5);
        peek(2, t, e); check("R6 cleared LC no err", e, 0);

        clr_valid = 1'b0;
        t = 1'b0;
        for (int i = 0; i < 200 && !t; i++) begin
            @(negedge clk); peek(2, t, e);
        end
        check("R4 marker set after clear released", t, 1);
        lc_set(2, 0, 5);
        repeat (200) @(negedge clk);
        peek(2, t, e); check("R8 stale marker kept", t, 1);
        check("R8 no event while disabled", events, 5);

        cfg_limit = '0;
        lc_set(2, 1, 5);
        repeat (100) @(negedge clk);
        check("R9 zero limit no event", events, 5);
        exp_q.push_back(4'd2);
        cfg_limit = 16'd3;
        wait_events("R5 stale marker times out", 6, 400);
        peek(2, t, e); check("R5 err after stale marker", e, 1);
        check("scoreboard drained", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule